// File: doc/BRIEF.md
# Scatter-Gather Descriptor Dispatch Front End

This block is the entry stage of a scatter-gather DMA dispatcher. Software builds an eight-word descriptor through a host write port: seven words land in a staging register, and the eighth (control) word, written with its go bit set, commits the whole descriptor into a descriptor queue in one step. The queue hands descriptors one at a time to a downstream transfer engine over a valid/ready interface. The engine reports the end of each transfer with a completion pulse that carries error and early-termination flags.

A small register bank sits beside the queue. It reports the queue state, the sequence numbers of the descriptors in flight and the sticky error and interrupt conditions. It holds the stop, fetch-hold, stop-on-condition and interrupt-enable controls, runs a fixed-length soft reset that flushes the queue, and drives one interrupt line.

Descriptor word order, by write index 0..7: read address low, write address low, length, burst/sequence (write burst 31:24, read burst 23:16, sequence 15:0), stride (write 31:16, read 15:0), read address high, write address high, control. Control word fields: channel 7:0, start-of-packet 8, end-of-packet 9, park reads 10, park writes 11, end on packet end 12, end on length 13, completion interrupt 14, early-termination interrupt 15, error interrupt mask 23:16, early done 24, go 31. A burst value of 0 means the largest burst. The host port has no back-pressure and accepts a write in every cycle that `bus_wr` is high. On the engine side a descriptor moves only in a cycle where `eng_valid` and `eng_ready` are both high. `eng_valid` never depends on `eng_ready`, and `eng_desc` stays stable while `eng_valid` waits.

Top module: `sgd_front`

## Requirements
- R1: A descriptor-space write (`bus_sel`=1) to index 0..6 stores that word in staging. On commit, `eng_desc[32*i+31:32*i]` carries the word written at index i, and the top word carries the committing control write.
- R2: Only a descriptor-space write to index 7 with bit 31 set pushes a descriptor. It is counted one cycle later. An index-7 write with bit 31 clear changes no fill level.
- R3: A commit while the queue holds FIFO_DEPTH entries is discarded. The fill level stays unchanged and status bit 10 (drop flag) sets. Status bit 2 shows full.
- R4: Register word 2 reads the queue count in both bits 31:16 and 15:0. Status bit 1 shows empty. Response reporting is fixed: status bit 3 reads 1, bit 4 reads 0, and word 3 reads 0.
- R5: `eng_valid` is high when the queue is non-empty, no descriptor is in flight and nothing gates dispatch. After a handshake, status bit 0 (busy) stays high and `eng_valid` stays low until `cmpl_valid`.
- R6: Register word 4 bits 15:0 hold the sequence field of the last dispatched descriptor, and bits 31:16 hold that of the last completed one.
- R7: Control bit 0 (stop) or control bit 5 (fetch hold) blocks dispatch. Status bit 5 reads stop AND NOT busy.
- R8: A completion with a nonzero error and control bit 2 set sets status bit 7. A completion with the early flag and control bit 3 set sets status bit 8. Either bit blocks dispatch while it is set.
- R9: Status bit 9 sets on a completion whose descriptor had bit 14, or bit 15 together with the early flag, or any error bit under its mask 23:16. The `irq` pin is status bit 9 AND control bit 4.
- R10: Writing 1 to status bits 7, 8, 9 or 10 at word 0 clears them. All other status bits ignore writes.
- R11: Writing control bit 1 holds status bit 6 (resetting) high for exactly RST_CYCLES (8) cycles. During that time the queue flushes, commits are ignored and nothing dispatches. The write clears stop, bits 7 and 8. Control bit 1 reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_sel | input | 1 | 1 selects descriptor space, 0 the register bank |
| bus_addr | input | 3 | Word index in the selected space |
| bus_wdata | input | 32 | Host write data |
| csr_raddr | input | 3 | Register bank read word index |
| csr_rdata | output | 32 | Register bank read data (combinational) |
| eng_valid | output | 1 | Descriptor offered to the engine |
| eng_ready | input | 1 | Engine accepts the offered descriptor |
| eng_desc | output | 256 | Offered descriptor, word i at bits 32*i+31:32*i |
| cmpl_valid | input | 1 | Engine completion pulse |
| cmpl_err | input | 8 | Error bits of the completing transfer |
| cmpl_early | input | 1 | Completing transfer ended early |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the queue past its depth. A design that let the extra commit through would corrupt the oldest entry and read back a fill of 5 or 0 instead of 4 with the drop flag set. It writes ones to read-only status bits and to the sticky bits. A wrong clear mask shows up as a lost full or empty indication, or as a sticky stop that never releases the engine. It counts the resetting window cycle by cycle and commits inside it. An off-by-one counter, or a commit that slips into a flushed queue, changes either the edge where bit 6 falls or the final fill level. It also completes descriptors with each interrupt cause and with global enable cleared, to separate the sticky interrupt bit from the gated pin.

// File: rtl/sgd_pkg.sv
`timescale 1ns/1ps
package sgd_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;
  localparam int DESC_W     = DESC_WORDS * WORD_W;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int CTL_OFS    = (DESC_WORDS - 1) * WORD_W;
  localparam int SEQ_OFS    = 3 * WORD_W;
  localparam int SEQ_W      = 16;
  localparam int GO_BIT     = 31;

  localparam logic [2:0] RG_STATUS = 3'd0;
  localparam logic [2:0] RG_CTRL   = 3'd1;
  localparam logic [2:0] RG_FILL   = 3'd2;
  localparam logic [2:0] RG_RESP   = 3'd3;
  localparam logic [2:0] RG_SEQ    = 3'd4;

  localparam int SB_BUSY   = 0;
  localparam int SB_EMPTY  = 1;
  localparam int SB_FULL   = 2;
  localparam int SB_REMPTY = 3;
  localparam int SB_RFULL  = 4;
  localparam int SB_STOPD  = 5;
  localparam int SB_RSTING = 6;
  localparam int SB_ERRSTP = 7;
  localparam int SB_ERLSTP = 8;
  localparam int SB_IRQ    = 9;
  localparam int SB_DROP   = 10;

  localparam int CB_STOP    = 0;
  localparam int CB_RESET   = 1;
  localparam int CB_ERRSTP  = 2;
  localparam int CB_ERLSTP  = 3;
  localparam int CB_GIE     = 4;
  localparam int CB_NOFETCH = 5;

  typedef struct packed {
    logic [7:0] err_mask;
    logic       early_irq;
    logic       done_irq;
  } irq_cfg_t;
endpackage

// File: rtl/sgd_desc_stage.sv
`timescale 1ns/1ps
module sgd_desc_stage
  import sgd_pkg::*;
#(
  parameter int NW = DESC_WORDS,
  parameter int DW = WORD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [$clog2(NW)-1:0] wr_idx,
  input  logic [DW-1:0]         wr_data,
  output logic [NW*DW-1:0]      commit_desc
);
  localparam int AW = $clog2(NW);

  // words below the control word are held; the control word is taken live
  for (genvar i = 0; i < NW - 1; i++) begin : g_word
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q <= '0;
      else if (wr_en && wr_idx == AW'(i))     q <= wr_data;
    end
    assign commit_desc[i*DW +: DW] = q;
  end
  assign commit_desc[(NW-1)*DW +: DW] = wr_data;
endmodule

// File: rtl/sgd_desc_fifo.sv
`timescale 1ns/1ps
module sgd_desc_fifo #(
  parameter int W     = 256,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  assign head  = mem[rp];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/sgd_csr_bank.sv
`timescale 1ns/1ps
module sgd_csr_bank
  import sgd_pkg::*;
#(
  parameter int CW         = 3,
  parameter int RST_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [2:0]       rd_addr,
  output logic [31:0]      rd_data,
  input  logic [CW-1:0]    fifo_cnt,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic             busy,
  input  logic             commit_drop,
  input  logic             disp_fire,
  input  logic [SEQ_W-1:0] disp_seq,
  input  logic             cmpl_fire,
  input  logic [SEQ_W-1:0] cmpl_seq,
  input  irq_cfg_t         cmpl_cfg,
  input  logic [7:0]       cmpl_err,
  input  logic             cmpl_early,
  output logic             irq,
  output logic             gate,
  output logic             resetting
);
  localparam int RCW = $clog2(RST_CYCLES + 1);

  logic c_stop, c_errstp, c_erlstp, c_gie, c_nofetch;
  logic s_errstp, s_erlstp, s_irq, s_drop;
  logic [RCW-1:0]   rst_cnt;
  logic [SEQ_W-1:0] seq_rd, seq_wr;
  logic [31:0]      status;
  logic             wr_ctl, wr_st, rst_req, irq_hit;
  logic             unused_bits;

  assign wr_ctl  = wr_en && (wr_addr == RG_CTRL);
  assign wr_st   = wr_en && (wr_addr == RG_STATUS);
  assign rst_req = wr_ctl && wr_data[CB_RESET];
  assign irq_hit = cmpl_cfg.done_irq || (cmpl_cfg.early_irq && cmpl_early) ||
                   (|(cmpl_cfg.err_mask & cmpl_err));
  assign unused_bits = ^{wr_data[31:11], wr_data[6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_stop    <= 1'b0;
      c_errstp  <= 1'b0;
      c_erlstp  <= 1'b0;
      c_gie     <= 1'b0;
      c_nofetch <= 1'b0;
      s_errstp  <= 1'b0;
      s_erlstp  <= 1'b0;
      s_irq     <= 1'b0;
      s_drop    <= 1'b0;
      rst_cnt   <= '0;
      seq_rd    <= '0;
      seq_wr    <= '0;
    end else begin
      if (wr_ctl) begin
        c_stop    <= wr_data[CB_STOP] && !wr_data[CB_RESET];
        c_errstp  <= wr_data[CB_ERRSTP];
        c_erlstp  <= wr_data[CB_ERLSTP];
        c_gie     <= wr_data[CB_GIE];
        c_nofetch <= wr_data[CB_NOFETCH];
      end
      if (rst_req)              rst_cnt <= RCW'(RST_CYCLES);
      else if (rst_cnt != '0)   rst_cnt <= rst_cnt - RCW'(1);

      // clears first, so an event in the same cycle wins
      if ((wr_st && wr_data[SB_ERRSTP]) || rst_req) s_errstp <= 1'b0;
      if ((wr_st && wr_data[SB_ERLSTP]) || rst_req) s_erlstp <= 1'b0;
      if (wr_st && wr_data[SB_IRQ])                 s_irq    <= 1'b0;
      if (wr_st && wr_data[SB_DROP])                s_drop   <= 1'b0;
      if (cmpl_fire && c_errstp && (cmpl_err != '0)) s_errstp <= 1'b1;
      if (cmpl_fire && c_erlstp && cmpl_early)       s_erlstp <= 1'b1;
      if (cmpl_fire && irq_hit)                      s_irq    <= 1'b1;
      if (commit_drop)                               s_drop   <= 1'b1;

      if (disp_fire) seq_rd <= disp_seq;
      if (cmpl_fire) seq_wr <= cmpl_seq;
    end
  end

  assign resetting = (rst_cnt != '0);
  assign gate      = c_stop || c_nofetch || s_errstp || s_erlstp || resetting;
  assign irq       = s_irq && c_gie;

  always_comb begin
    status            = '0;
    status[SB_BUSY]   = busy;
    status[SB_EMPTY]  = fifo_empty;
    status[SB_FULL]   = fifo_full;
    status[SB_REMPTY] = 1'b1;
    status[SB_RFULL]  = 1'b0;
    status[SB_STOPD]  = c_stop && !busy;
    status[SB_RSTING] = resetting;
    status[SB_ERRSTP] = s_errstp;
    status[SB_ERLSTP] = s_erlstp;
    status[SB_IRQ]    = s_irq;
    status[SB_DROP]   = s_drop;
  end

  always_comb begin
    case (rd_addr)
      RG_STATUS: rd_data = status;
      RG_CTRL:   rd_data = {26'd0, c_nofetch, c_gie, c_erlstp, c_errstp, 1'b0, c_stop};
      RG_FILL:   rd_data = {{(16-CW){1'b0}}, fifo_cnt, {(16-CW){1'b0}}, fifo_cnt};
      RG_SEQ:    rd_data = {seq_wr, seq_rd};
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sgd_front.sv
`timescale 1ns/1ps
module sgd_front
  import sgd_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [2:0]        csr_raddr,
  output logic [31:0]       csr_rdata,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [DESC_W-1:0] eng_desc,
  input  logic              cmpl_valid,
  input  logic [7:0]        cmpl_err,
  input  logic              cmpl_early,
  output logic              irq
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [DESC_W-1:0] staged, head;
  logic [CW-1:0]     fifo_cnt;
  logic fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic commit, commit_drop, gate, resetting;
  logic in_flight, disp_fire, cmpl_fire;
  irq_cfg_t          head_cfg, fl_cfg;
  logic [SEQ_W-1:0]  head_seq, fl_seq;

  sgd_desc_stage #(.NW(DESC_WORDS), .DW(WORD_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr && bus_sel), .wr_idx(bus_addr), .wr_data(bus_wdata),
    .commit_desc(staged)
  );

  assign commit      = bus_wr && bus_sel && (bus_addr == IDX_W'(DESC_WORDS - 1)) &&
                       bus_wdata[GO_BIT];
  assign fifo_push   = commit && !fifo_full && !resetting;
  assign commit_drop = commit && fifo_full && !resetting;

  sgd_desc_fifo #(.W(DESC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(resetting),
    .push(fifo_push), .push_data(staged), .pop(fifo_pop),
    .head(head), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
  );

  assign eng_valid = !fifo_empty && !in_flight && !gate;
  assign eng_desc  = head;
  assign disp_fire = eng_valid && eng_ready;
  assign fifo_pop  = disp_fire;
  assign cmpl_fire = cmpl_valid && in_flight;

  assign head_cfg = '{err_mask:  head[CTL_OFS+16 +: 8],
                      early_irq: head[CTL_OFS+15],
                      done_irq:  head[CTL_OFS+14]};
  assign head_seq = head[SEQ_OFS +: SEQ_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_flight <= 1'b0;
      fl_cfg    <= '0;
      fl_seq    <= '0;
    end else if (disp_fire) begin
      in_flight <= 1'b1;
      fl_cfg    <= head_cfg;
      fl_seq    <= head_seq;
    end else if (cmpl_fire) begin
      in_flight <= 1'b0;
    end
  end

  sgd_csr_bank #(.CW(CW), .RST_CYCLES(RST_CYCLES)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr && !bus_sel), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .rd_addr(csr_raddr), .rd_data(csr_rdata),
    .fifo_cnt(fifo_cnt), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .busy(in_flight), .commit_drop(commit_drop),
    .disp_fire(disp_fire), .disp_seq(head_seq),
    .cmpl_fire(cmpl_fire), .cmpl_seq(fl_seq), .cmpl_cfg(fl_cfg),
    .cmpl_err(cmpl_err), .cmpl_early(cmpl_early),
    .irq(irq), .gate(gate), .resetting(resetting)
  );
endmodule

// File: rtl/sgd_front_chk.sv
`timescale 1ns/1ps
module sgd_front_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_valid,
  input logic          eng_ready,
  input logic          cmpl_valid,
  input logic          busy,
  input logic          push,
  input logic          pop,
  input logic          resetting,
  input logic [CW-1:0] count
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_commit_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |=> count == $past(count) + CW'(1));

  p_one_flight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && eng_ready |=> !eng_valid && busy);

  p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cmpl_valid |=> busy);

  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resetting |=> count == '0);

  p_reset_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(resetting) |-> $past(resetting, 8));
endmodule

bind sgd_front sgd_front_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_valid(eng_valid), .eng_ready(eng_ready),
  .cmpl_valid(cmpl_valid), .busy(in_flight), .push(fifo_push), .pop(fifo_pop),
  .resetting(resetting), .count(fifo_cnt)
);

// File: tb/sgd_front_test.sv
`timescale 1ns/1ps
module sgd_front_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_sel = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [2:0]   csr_raddr = '0;
  logic [31:0]  csr_rdata;
  logic         eng_valid, eng_ready = 1'b0;
  logic [255:0] eng_desc;
  logic         cmpl_valid = 1'b0, cmpl_early = 1'b0;
  logic [7:0]   cmpl_err = '0;
  logic         irq;
  int           total = 0, bad = 0;
  logic         finished = 1'b0;

  always #10 clk = ~clk;

  sgd_front uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .csr_raddr(csr_raddr),
    .csr_rdata(csr_rdata), .eng_valid(eng_valid), .eng_ready(eng_ready),
    .eng_desc(eng_desc), .cmpl_valid(cmpl_valid), .cmpl_err(cmpl_err),
    .cmpl_early(cmpl_early), .irq(irq)
  );

  typedef struct packed {
    logic [255:0] d;
    logic [7:0]   err;
    logic         early;
    logic         irq;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{d: {32'h8000_4000, 32'h0000_0000, 32'h0000_0001, 32'h0004_0004,
          32'h1020_0011, 32'h0000_0100, 32'h2000_0000, 32'h1000_0000},
      err: 8'h00, early: 1'b0, irq: 1'b1},
    '{d: {32'h8000_0300, 32'h0000_0000, 32'h0000_0000, 32'h0001_0001,
          32'h0000_0022, 32'h0000_0040, 32'h2000_1000, 32'h1000_2000},
      err: 8'h00, early: 1'b0, irq: 1'b0},
    '{d: {32'h8003_0000, 32'h0000_0007, 32'h0000_0009, 32'h0000_0000,
          32'h0000_0033, 32'h0000_0800, 32'h3000_0000, 32'h1100_0000},
      err: 8'h02, early: 1'b0, irq: 1'b1},
    '{d: {32'h8000_8000, 32'hABCD_0000, 32'h1234_0000, 32'h0002_0000,
          32'hFF00_0044, 32'h0000_0010, 32'h0000_0ABC, 32'h0000_0DEF},
      err: 8'h04, early: 1'b1, irq: 1'b1}
  };

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    csr_raddr = a;
    #1;
    v = csr_rdata;
  endtask

  task automatic push_desc(input logic [255:0] d);
    for (int w = 0; w < 8; w++) wr(1'b1, 3'(w), d[32*w +: 32]);
  endtask

  task automatic consume();
    @(negedge clk);
    eng_ready = 1'b1;
    @(negedge clk);
    eng_ready = 1'b0;
  endtask

  task automatic complete(input logic [7:0] e, input logic early);
    @(negedge clk);
    cmpl_valid = 1'b1; cmpl_err = e; cmpl_early = early;
    @(negedge clk);
    cmpl_valid = 1'b0; cmpl_err = '0; cmpl_early = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(3'd0, v); chk("R4 reset status", v, 32'h0000_000A);
    rd(3'd1, v); chk("R7 reset control", v, 0);
    rd(3'd2, v); chk("R4 reset fill", v, 0);
    rd(3'd3, v); chk("R4 response fill", v, 0);
    rd(3'd4, v); chk("R6 reset seq", v, 0);
    chk("R5 reset valid", eng_valid, 0);
    chk("R9 reset irq", irq, 0);

    // control word without go
    wr(1'b1, 3'd7, 32'h0000_4000);
    rd(3'd2, v); chk("R2 no-go write ignored", v, 0);

    wr(1'b0, 3'd1, 32'h0000_0010);
    // table walk: push, dispatch, complete, interrupt
    for (int i = 0; i < 4; i++) begin
      push_desc(VEC[i].d);
      rd(3'd2, v); chk("R2 R4 fill after commit", v, 32'h0001_0001);
      chk("R5 valid offered", eng_valid, 1);
      chk("R1 descriptor words", eng_desc, VEC[i].d);
      consume();
      rd(3'd0, v); chk("R5 busy after dispatch", v[0], 1);
      chk("R5 no second offer", eng_valid, 0);
      rd(3'd4, v); chk("R6 read seq", v[15:0], VEC[i].d[111:96]);
      complete(VEC[i].err, VEC[i].early);
      rd(3'd4, v); chk("R6 write seq", v[31:16], VEC[i].d[111:96]);
      rd(3'd0, v); chk("R9 irq status", v[9], VEC[i].irq);
      chk("R5 busy cleared", v[0], 0);
      chk("R9 irq pin", irq, VEC[i].irq);
      wr(1'b0, 3'd0, 32'h0000_0200);
      rd(3'd0, v); chk("R10 irq cleared", v[9], 0);
    end

    // global enable gates the pin only
    push_desc(VEC[0].d);
    consume();
    complete(8'h00, 1'b0);
    wr(1'b0, 3'd1, 32'h0000_0000);
    rd(3'd0, v); chk("R9 sticky with gie off", v[9], 1);
    chk("R9 pin masked", irq, 0);
    wr(1'b0, 3'd0, 32'h0000_0200);
    rd(3'd0, v); chk("R10 clear irq", v[9], 0);

    // overflow with fetch hold
    wr(1'b0, 3'd1, 32'h0000_0020);
    for (int i = 0; i < 5; i++) push_desc(VEC[1].d);
    rd(3'd2, v); chk("R3 fill at depth", v, 32'h0004_0004);
    rd(3'd0, v); chk("R3 full and drop", v, 32'h0000_040C);
    chk("R7 fetch hold blocks", eng_valid, 0);
    wr(1'b0, 3'd0, 32'h0000_007F);
    rd(3'd0, v); chk("R10 read-only bits", v, 32'h0000_040C);
    wr(1'b0, 3'd0, 32'h0000_0400);
    rd(3'd0, v); chk("R10 drop cleared", v, 32'h0000_000C);

    // stop on error
    wr(1'b0, 3'd1, 32'h0000_0004);
    chk("R5 offer after release", eng_valid, 1);
    consume();
    complete(8'h01, 1'b0);
    rd(3'd0, v); chk("R8 error stop bit", v[7], 1);
    chk("R8 error stop blocks", eng_valid, 0);
    wr(1'b0, 3'd0, 32'h0000_0080);
    chk("R8 R10 error stop released", eng_valid, 1);

    // stop on early termination
    wr(1'b0, 3'd1, 32'h0000_0008);
    consume();
    complete(8'h00, 1'b1);
    rd(3'd0, v); chk("R8 early stop bit", v[8], 1);
    chk("R8 early stop blocks", eng_valid, 0);
    wr(1'b0, 3'd0, 32'h0000_0100);
    chk("R8 early stop released", eng_valid, 1);

    // stop control
    wr(1'b0, 3'd1, 32'h0000_0001);
    chk("R7 stop blocks", eng_valid, 0);
    rd(3'd0, v); chk("R7 stopped status", v[5], 1);

    // soft reset window
    wr(1'b0, 3'd1, 32'h0000_0013);
    rd(3'd0, v); chk("R11 resetting raised", v[6], 1);
    wr(1'b1, 3'd7, 32'h8000_0000);
    rd(3'd2, v); chk("R11 flushed, commit ignored", v, 0);
    repeat (5) @(negedge clk);
    rd(3'd0, v); chk("R11 resetting last cycle", v[6], 1);
    @(negedge clk);
    rd(3'd0, v); chk("R11 resetting dropped after 8", v[6], 0);
    chk("R11 stop cleared", v[5], 0);
    rd(3'd1, v); chk("R11 control after reset", v, 32'h0000_0010);
    rd(3'd2, v); chk("R11 fill after reset", v, 0);
    chk("R11 nothing offered", eng_valid, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule